// File: doc/BRIEF.md
# Vectored Interrupt Controller with Word Register Bank

This block gathers up to 32 interrupt request lines into one processor interrupt. A request that is allowed in is latched into a status register. An enable register masks the status register to give a pending set. The controller reports the lowest-numbered pending source as a vector number and raises a single interrupt output. Software works through eight 32-bit word registers on a simple bus. The bus has a byte address, a write strobe, write data and combinational read data.

Each input is passed through a two-flop synchroniser. An elaboration-time mask then picks, for each input, between level capture and rising-edge capture. A master register holds two gates. One gate lets request lines reach the status register. The other lets the pending set drive the interrupt output. While capture is gated off, software may write the status register directly to raise test interrupts. Three write-only registers change bits without a read-modify-write: one sets enables, one clears enables and one acknowledges status.

Top module: `irqc_top`

## Requirements
- R1: Registers are selected by word index (byte address = index × 4): 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. A direct write to index 2 loads the enable register. Indices 3, 4 and 5 read as zero.
- R2: Index 1 (pending) always reads as status AND enable. Writes to it have no effect.
- R3: Index 6 (vector) reads the index of the lowest-numbered set pending bit, or 0xFFFFFFFF when none is set. Writes to it have no effect.
- R4: `irq_out` is high exactly when master bit 0 is 1 and at least one pending bit is set. It follows register state combinationally.
- R5: A write to the master register keeps only bits 1:0. Bits 31:2 read as zero.
- R6: A write to index 0 loads the status register when master bit 1 is 0. It is ignored when master bit 1 is 1.
- R7: A write to index 3 clears every status bit whose written bit is 1 and leaves the other bits unchanged.
- R8: A write to index 4 ORs the data into the enable register. A write to index 5 clears the enable bits written as 1.
- R9: A level-kind input held high while master bit 1 is 1 sets its status bit. The bit is set at the third rising clock edge after the input changes: two synchroniser edges, then one latch edge.
- R10: An edge-kind input sets its status bit once per rising edge. Once acknowledged, the bit stays clear while the input remains high, and it is set again on the next rising edge.
- R11: While master bit 1 is 0, no input changes the status register.
- R12: When a capture and an acknowledge hit the same status bit in the same cycle, the bit ends set.
- R13: After reset the status, enable and master registers read zero, the vector reads 0xFFFFFFFF and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (5) | Byte address; bits 4:2 select the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq_in | input | NUM_SRC (32) | Interrupt request lines |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The bench builds the block with 32 sources and an edge mask of 0x0000FF00. Inputs 8 to 15 are therefore edge-kind and the rest are level-kind, so one build covers both capture styles. That mask lets the bench hold a level input (bit 2) high against an acknowledge to show the capture winning. It also holds an edge input (bit 9) high to show a single capture that stays cleared after acknowledge. The synchroniser depth is left at two, which fixes the three-edge latency the bench samples against.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int WORD_W = 32;
  localparam int IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    RG_STAT   = 3'd0,
    RG_PEND   = 3'd1,
    RG_ENAB   = 3'd2,
    RG_ACK    = 3'd3,
    RG_SETEN  = 3'd4,
    RG_CLREN  = 3'd5,
    RG_VEC    = 3'd6,
    RG_MASTER = 3'd7
  } reg_idx_e;

  // Lowest set bit index, all ones when the word is empty.
  function automatic logic [WORD_W-1:0] lowest_vec(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    r = '1;
    for (int k = WORD_W - 1; k >= 0; k--) begin
      if (v[k]) r = WORD_W'(k);
    end
    return r;
  endfunction

  // Status update: software load, then acknowledge, then capture on top.
  function automatic logic [WORD_W-1:0] status_next(
    input logic [WORD_W-1:0] cur,
    input logic              sw_load,
    input logic [WORD_W-1:0] sw_val,
    input logic              ack_hit,
    input logic [WORD_W-1:0] ack_val,
    input logic [WORD_W-1:0] cap
  );
    logic [WORD_W-1:0] r;
    r = sw_load ? sw_val : cur;
    if (ack_hit) r = r & ~ack_val;
    return r | cap;
  endfunction

  function automatic logic [WORD_W-1:0] enable_next(
    input logic [WORD_W-1:0] cur,
    input logic              load,
    input logic              set_hit,
    input logic              clr_hit,
    input logic [WORD_W-1:0] val
  );
    logic [WORD_W-1:0] r;
    r = cur;
    if (load)    r = val;
    if (set_hit) r = r | val;
    if (clr_hit) r = r & ~val;
    return r;
  endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int               NUM_SRC     = 32,
  parameter logic [NUM_SRC-1:0] KIND_EDGE = '0,
  parameter int               SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] raw_in,
  input  logic               hw_en,
  output logic [NUM_SRC-1:0] cap_req
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [NUM_SRC-1:0] synced;
  logic [NUM_SRC-1:0] prev;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain   <= '0;
        prev[i] <= 1'b0;
      end else begin
        chain   <= {chain[SYNC_STAGES-2:0], raw_in[i]};
        prev[i] <= chain[TOP];
      end
    end

    assign synced[i] = chain[TOP];

    if (KIND_EDGE[i]) begin : g_edge
      assign cap_req[i] = hw_en & synced[i] & ~prev[i];
    end else begin : g_level
      assign cap_req[i] = hw_en & synced[i];
    end
  end

  // R11: nothing is requested while capture is gated off
  assert_gate_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_en |-> (cap_req == '0));

endmodule

// File: rtl/irqc_vector.sv
module irqc_vector #(
  parameter int NUM_SRC = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            pend,
  output logic [irqc_pkg::WORD_W-1:0]   vec,
  output logic                          any
);
  import irqc_pkg::*;

  logic [WORD_W-1:0] pend_w;

  assign pend_w = WORD_W'(pend);
  assign vec    = lowest_vec(pend_w);
  assign any    = (vec != '1);

  // R3: the reported source is pending and nothing below it is
  assert_vec_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (pend_w[vec[4:0]] && ((pend_w & ((WORD_W'(1) << vec[4:0]) - 1)) == '0)));

  assert_vec_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> (pend_w == '0));

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int NUM_SRC = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [irqc_pkg::IDX_W-1:0]  wr_idx,
  input  logic [irqc_pkg::WORD_W-1:0] wdata,
  input  logic [NUM_SRC-1:0]          cap,
  output logic [NUM_SRC-1:0]          status,
  output logic [NUM_SRC-1:0]          enable,
  output logic [1:0]                  master
);
  import irqc_pkg::*;

  logic wr_stat, wr_ack, wr_enab, wr_set, wr_clr, wr_master;
  logic [WORD_W-1:0] stat_n, enab_n;

  assign wr_stat   = wr_en && (wr_idx == RG_STAT) && !master[1];
  assign wr_ack    = wr_en && (wr_idx == RG_ACK);
  assign wr_enab   = wr_en && (wr_idx == RG_ENAB);
  assign wr_set    = wr_en && (wr_idx == RG_SETEN);
  assign wr_clr    = wr_en && (wr_idx == RG_CLREN);
  assign wr_master = wr_en && (wr_idx == RG_MASTER);

  always_comb begin
    stat_n = status_next(WORD_W'(status), wr_stat, wdata, wr_ack, wdata, WORD_W'(cap));
    enab_n = enable_next(WORD_W'(enable), wr_enab, wr_set, wr_clr, wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      master <= '0;
    end else begin
      status <= stat_n[NUM_SRC-1:0];
      enable <= enab_n[NUM_SRC-1:0];
      if (wr_master) master <= wdata[1:0];
    end
  end

  // R7: acknowledged bits with no competing capture are clear next cycle
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> ((status & $past(wdata[NUM_SRC-1:0] & ~cap)) == '0));

  // R12: a capture always leaves its bit set
  assert_capture_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cap != '0) |=> ((status & $past(cap)) == $past(cap)));

  // R6: with capture on, only an acknowledge can clear status bits
  assert_sw_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (master[1] && !wr_ack) |=> (($past(status) & ~status) == '0));

  // R11: with capture off and no software load, no status bit appears
  assert_no_new_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!master[1] && !(wr_en && wr_idx == RG_STAT)) |=> ((status & ~$past(status)) == '0));

  // R8: set-enable leaves every written bit set
  assert_set_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((enable & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));

  // R8: clear-enable leaves every written bit clear
  assert_clr_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((enable & $past(wdata[NUM_SRC-1:0])) == '0));

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int                 NUM_SRC     = 32,
  parameter logic [NUM_SRC-1:0] KIND_EDGE   = '0,
  parameter int                 SYNC_STAGES = 2,
  parameter int                 ADDR_W      = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               irq_out
);
  import irqc_pkg::*;

  logic [IDX_W-1:0]   idx;
  logic [NUM_SRC-1:0] cap, status, enable, pend;
  logic [1:0]         master;
  logic [WORD_W-1:0]  vec;
  logic               any;

  assign idx = bus_addr[IDX_W+1:2];

  irqc_capture #(
    .NUM_SRC(NUM_SRC), .KIND_EDGE(KIND_EDGE), .SYNC_STAGES(SYNC_STAGES)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .raw_in(irq_in), .hw_en(master[1]), .cap_req(cap)
  );

  irqc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_idx(idx), .wdata(bus_wdata),
    .cap(cap), .status(status), .enable(enable), .master(master)
  );

  assign pend = status & enable;

  irqc_vector #(.NUM_SRC(NUM_SRC)) u_vec (
    .clk(clk), .rst_n(rst_n), .pend(pend), .vec(vec), .any(any)
  );

  assign irq_out = master[0] & any;

  always_comb begin
    unique case (idx)
      RG_STAT:   bus_rdata = WORD_W'(status);
      RG_PEND:   bus_rdata = WORD_W'(pend);
      RG_ENAB:   bus_rdata = WORD_W'(enable);
      RG_VEC:    bus_rdata = vec;
      RG_MASTER: bus_rdata = WORD_W'(master);
      default:   bus_rdata = '0;
    endcase
  end

  // R4: the interrupt output agrees with the vector finder and the gate
  assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (master[0] && (vec != '1)));

  // R5: master reads never show bits above 1
  assert_master_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == RG_MASTER) |-> (bus_rdata[31:2] == '0));

endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;

  localparam int NV = 39;
  // {write, index, requirement, data, expected}
  localparam logic [71:0] TBL [NV] = '{
    {1'b1, 3'd7, 4'd5, 32'hFFFFFFFC, 32'h0},        // R5
    {1'b0, 3'd7, 4'd5, 32'h0, 32'h0},               // R5
    {1'b1, 3'd7, 4'd5, 32'hFFFFFFFD, 32'h0},        // R5
    {1'b0, 3'd7, 4'd5, 32'h0, 32'h1},               // R5
    {1'b1, 3'd0, 4'd6, 32'h00000A50, 32'h0},        // R6
    {1'b0, 3'd0, 4'd6, 32'h0, 32'h00000A50},        // R6
    {1'b0, 3'd1, 4'd2, 32'h0, 32'h0},               // R2
    {1'b0, 3'd6, 4'd3, 32'h0, 32'hFFFFFFFF},        // R3
    {1'b1, 3'd4, 4'd8, 32'h00000040, 32'h0},        // R8
    {1'b0, 3'd2, 4'd8, 32'h0, 32'h00000040},        // R8
    {1'b0, 3'd1, 4'd2, 32'h0, 32'h00000040},        // R2
    {1'b0, 3'd6, 4'd3, 32'h0, 32'h6},               // R3
    {1'b1, 3'd4, 4'd8, 32'h00000810, 32'h0},        // R8
    {1'b0, 3'd2, 4'd8, 32'h0, 32'h00000850},        // R8
    {1'b0, 3'd1, 4'd2, 32'h0, 32'h00000850},        // R2
    {1'b0, 3'd6, 4'd3, 32'h0, 32'h4},               // R3
    {1'b1, 3'd5, 4'd8, 32'h00000010, 32'h0},        // R8
    {1'b0, 3'd2, 4'd8, 32'h0, 32'h00000840},        // R8
    {1'b0, 3'd6, 4'd3, 32'h0, 32'h6},               // R3
    {1'b1, 3'd3, 4'd7, 32'h00000040, 32'h0},        // R7
    {1'b0, 3'd0, 4'd7, 32'h0, 32'h00000A10},        // R7
    {1'b0, 3'd1, 4'd2, 32'h0, 32'h00000800},        // R2
    {1'b0, 3'd6, 4'd3, 32'h0, 32'hB},               // R3
    {1'b1, 3'd1, 4'd2, 32'hFFFFFFFF, 32'h0},        // R2
    {1'b0, 3'd1, 4'd2, 32'h0, 32'h00000800},        // R2
    {1'b1, 3'd6, 4'd3, 32'h0, 32'h0},               // R3
    {1'b0, 3'd6, 4'd3, 32'h0, 32'hB},               // R3
    {1'b0, 3'd3, 4'd1, 32'h0, 32'h0},               // R1
    {1'b0, 3'd4, 4'd1, 32'h0, 32'h0},               // R1
    {1'b0, 3'd5, 4'd1, 32'h0, 32'h0},               // R1
    {1'b1, 3'd2, 4'd1, 32'hFFFFFFFF, 32'h0},        // R1
    {1'b0, 3'd2, 4'd1, 32'h0, 32'hFFFFFFFF},        // R1
    {1'b0, 3'd1, 4'd2, 32'h0, 32'h00000A10},        // R2
    {1'b0, 3'd6, 4'd3, 32'h0, 32'h4},               // R3
    {1'b1, 3'd0, 4'd6, 32'h80000000, 32'h0},        // R6
    {1'b0, 3'd6, 4'd3, 32'h0, 32'h1F},              // R3
    {1'b0, 3'd1, 4'd2, 32'h0, 32'h80000000},        // R2
    {1'b1, 3'd0, 4'd6, 32'h0, 32'h0},               // R6
    {1'b0, 3'd6, 4'd3, 32'h0, 32'hFFFFFFFF}         // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irqc_top #(.NUM_SRC(32), .KIND_EDGE(32'h0000FF00)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = {idx, 2'b00};
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] idx, output logic [31:0] d);
    bus_addr = {idx, 2'b00};
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R13: reset state
    bus_read(3'd0, rd); check("R13 status", rd, 32'h0);
    bus_read(3'd2, rd); check("R13 enable", rd, 32'h0);
    bus_read(3'd7, rd); check("R13 master", rd, 32'h0);
    bus_read(3'd6, rd); check("R13 vector", rd, 32'hFFFFFFFF);
    check("R13 irq_out", 32'(irq_out), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][71]) begin
        bus_write(TBL[i][70:68], TBL[i][63:32]);
      end else begin
        bus_read(TBL[i][70:68], rd);
        check($sformatf("R%0d row %0d", TBL[i][67:64], i), rd, TBL[i][31:0]);
      end
    end
    check("R4 idle output", 32'(irq_out), 32'h0);

    // R4: output gating by master bit 0 (enable is all ones here)
    bus_write(3'd0, 32'h8);
    check("R4 pending and gate on", 32'(irq_out), 32'h1);
    bus_write(3'd7, 32'h0);
    check("R4 gate off", 32'(irq_out), 32'h0);
    bus_write(3'd7, 32'h1);
    bus_write(3'd0, 32'h0);
    check("R4 nothing pending", 32'(irq_out), 32'h0);

    // R11: capture gated off, level bit 5 and edge bit 12 toggle
    @(negedge clk);
    irq_in = 32'h00001020;
    idle(5);
    bus_read(3'd0, rd); check("R11 no capture", rd, 32'h0);
    irq_in = '0;
    idle(4);

    // R6: status write ignored with capture on
    bus_write(3'd7, 32'h3);
    bus_write(3'd0, 32'h0000FFFF);
    bus_read(3'd0, rd); check("R6 write ignored", rd, 32'h0);

    // R9: level bit 2, latency of three edges
    @(negedge clk);
    irq_in[2] = 1'b1;
    idle(2);
    bus_read(3'd0, rd); check("R9 not yet captured", rd, 32'h0);
    idle(1);
    bus_read(3'd0, rd); check("R9 captured", rd, 32'h4);
    bus_read(3'd6, rd); check("R9 vector", rd, 32'h2);
    // R12: acknowledge while level still asserted
    bus_write(3'd3, 32'h4);
    bus_read(3'd0, rd); check("R12 capture beats ack", rd, 32'h4);
    irq_in[2] = 1'b0;
    idle(4);
    bus_write(3'd3, 32'h4);
    bus_read(3'd0, rd); check("R7 ack after release", rd, 32'h0);

    // R10: edge bit 9
    irq_in[9] = 1'b1;
    idle(4);
    bus_read(3'd0, rd); check("R10 edge captured", rd, 32'h200);
    bus_write(3'd3, 32'h200);
    idle(3);
    bus_read(3'd0, rd); check("R10 held high stays clear", rd, 32'h0);
    irq_in[9] = 1'b0;
    idle(3);
    irq_in[9] = 1'b1;
    idle(4);
    bus_read(3'd0, rd); check("R10 second edge", rd, 32'h200);
    check("R4 output from capture", 32'(irq_out), 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule